// File: doc/BRIEF.md
# Dual-Channel Disk Interrupt Status Aggregator

This block keeps the pending-interrupt state of a two-channel IDE host controller and turns it into one level-sensitive request line. Each channel has a single pending flag. That flag can be seen at two byte locations on the configuration port. The first is a combined mode byte, which also holds one mask bit per channel. The second is a per-channel byte: a primary status byte for channel 0 and a timing byte for channel 1. Both views read from the same storage, so they cannot disagree.

A drive line going high marks its channel pending. A drive line going low withdraws the pending flag. Software acknowledges an interrupt by writing a one to the flag through either of its two locations, and writing a zero there has no effect. The request output is the OR of the pending flags that are not masked, and it is registered.

The three register addresses are parameters, so the block can be placed anywhere in a configuration space. The non-status bits of the primary and timing bytes are kept as plain storage for neighbouring timing logic.

Top module: `ideirq_agg`

## Requirements
- R1: In the mode byte, bit 2 is channel 0 pending, bit 3 is channel 1 pending, bit 4 is channel 0 mask and bit 5 is channel 1 mask. Bits 0, 1, 6 and 7 always read 0 and ignore writes.
- R2: Bit 2 of the primary byte always reads the same as channel 0 pending. Bit 4 of the timing byte always reads the same as channel 1 pending.
- R3: When a drive line goes from low to high, its pending flag reads 1 after the next clock edge.
- R4: When a drive line goes from high to low, its pending flag reads 0 after the next clock edge.
- R5: Writing 1 to a pending bit clears it, through the mode byte or through the primary or timing byte. Writing 0 leaves it unchanged. A write can never set a pending flag.
- R6: If a drive line rises in the same cycle as a write-one-to-clear of its flag, the flag ends up set.
- R7: The two mask bits are ordinary read/write bits, written through the mode byte.
- R8: The request is (pending0 AND NOT mask0) OR (pending1 AND NOT mask1). It is registered, so it reflects a state change one clock after that change.
- R9: All bits of the primary and timing bytes other than their pending bit are plain read/write storage.
- R10: Synchronous active-high reset clears all flags, masks and storage and drops the request. An address other than the three registers reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_irq | input | 2 | Raw interrupt level from each channel's drive, bit c for channel c |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_addr | input | ADDR_W | Write address |
| cfg_wdata | input | DATA_W | Write data |
| cfg_raddr | input | ADDR_W | Read address |
| cfg_rdata | output | DATA_W | Read data, combinational from cfg_raddr |
| irq_req | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with a 6-bit address and places the three registers at 0x05, 0x0C and 0x13 instead of the defaults. This shows that decoding follows the parameters, and it leaves addresses 0x00 and 0x3F free to probe the unmapped case. With these values the bench reaches both acknowledge paths for each channel, an edge colliding with an acknowledge, every mask combination, and the one-cycle lag of the request.

// File: rtl/ideirq_pkg.sv
package ideirq_pkg;

   localparam int unsigned NCH          = 2;
   localparam int unsigned BYTE_W       = 8;
   localparam int unsigned MODE_PEND_LO = 2;
   localparam int unsigned MODE_MASK_LO = 4;
   localparam int unsigned PRI_PEND_BIT = 2;
   localparam int unsigned TIM_PEND_BIT = 4;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PRI  = 2'd1,
      SEL_TIM  = 2'd2,
      SEL_MODE = 2'd3
   } regsel_e;

endpackage

// File: rtl/ideirq_chan.sv
module ideirq_chan (
   input  logic clk,
   input  logic rst,
   input  logic drv_i,
   input  logic clr_i,
   output logic pend_o
);

   logic prev_q;
   logic pend_q;
   logic rise;
   logic fall;

   assign rise = drv_i & ~prev_q;
   assign fall = ~drv_i & prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= drv_i;
         if (rise)
            pend_q <= 1'b1;
         else if (fall || clr_i)
            pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
      (drv_i && !prev_q) |=> pend_q); // R3

   AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!drv_i && prev_q) |=> !pend_q); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !(drv_i && !prev_q)) |=> !pend_q); // R5

   AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (rst)
      (!pend_q && !(drv_i && !prev_q)) |=> !pend_q); // R5

   AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (rst)
      (clr_i && drv_i && !prev_q) |=> pend_q); // R6

endmodule

// File: rtl/ideirq_regs.sv
module ideirq_regs
   import ideirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PRI_ADDR  = 8'h20,
   parameter logic [ADDR_W-1:0] TIM_ADDR  = 8'h24,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h2A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   input  logic [NCH-1:0]    pend_i,
   output logic [NCH-1:0]    clr_o,
   output logic [NCH-1:0]    mask_o,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [DATA_W-1:0] PRI_KEEP = ~(DATA_W'(1) << PRI_PEND_BIT);
   localparam logic [DATA_W-1:0] TIM_KEEP = ~(DATA_W'(1) << TIM_PEND_BIT);

   regsel_e wsel;
   regsel_e rsel;
   logic [DATA_W-1:0] pri_q;
   logic [DATA_W-1:0] tim_q;
   logic [NCH-1:0]    mask_q;

   function automatic regsel_e decode(input logic [ADDR_W-1:0] a);
      if (a == PRI_ADDR)       return SEL_PRI;
      else if (a == TIM_ADDR)  return SEL_TIM;
      else if (a == MODE_ADDR) return SEL_MODE;
      else                     return SEL_NONE;
   endfunction

   assign wsel = wr_en ? decode(waddr) : SEL_NONE;
   assign rsel = decode(raddr);

   // acknowledge strobes: channel 0 from primary or mode, channel 1 from timing or mode
   always_comb begin
      clr_o[0] = ((wsel == SEL_PRI)  && wdata[PRI_PEND_BIT]) ||
                 ((wsel == SEL_MODE) && wdata[MODE_PEND_LO]);
      clr_o[1] = ((wsel == SEL_TIM)  && wdata[TIM_PEND_BIT]) ||
                 ((wsel == SEL_MODE) && wdata[MODE_PEND_LO+1]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pri_q  <= '0;
         tim_q  <= '0;
         mask_q <= '0;
      end else begin
         case (wsel)
            SEL_PRI:  pri_q  <= wdata & PRI_KEEP;
            SEL_TIM:  tim_q  <= wdata & TIM_KEEP;
            SEL_MODE: mask_q <= wdata[MODE_MASK_LO +: NCH];
            default:  ;
         endcase
      end
   end

   assign mask_o = mask_q;

   always_comb begin
      rdata = '0;
      case (rsel)
         SEL_PRI: begin
            rdata = pri_q;
            rdata[PRI_PEND_BIT] = pend_i[0];
         end
         SEL_TIM: begin
            rdata = tim_q;
            rdata[TIM_PEND_BIT] = pend_i[1];
         end
         SEL_MODE: begin
            rdata[MODE_PEND_LO +: NCH] = pend_i;
            rdata[MODE_MASK_LO +: NCH] = mask_q;
         end
         default: rdata = '0;
      endcase
   end

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr_en && waddr == MODE_ADDR) |=> mask_q == $past(wdata[MODE_MASK_LO +: NCH])); // R7

   AST_PRI_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && waddr == PRI_ADDR) |=> $stable(pri_q)); // R9

   AST_PRI_PEND_FREE: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> !pri_q[PRI_PEND_BIT]); // R2

endmodule

// File: rtl/ideirq_reduce.sv
module ideirq_reduce
   import ideirq_pkg::*;
(
   input  logic           clk,
   input  logic           rst,
   input  logic [NCH-1:0] pend_i,
   input  logic [NCH-1:0] mask_i,
   output logic           irq_o
);

   logic [NCH-1:0] live;
   logic           irq_q;

   for (genvar c = 0; c < NCH; c++) begin : g_live
      assign live[c] = pend_i[c] & ~mask_i[c];
   end

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= |live;
   end

   assign irq_o = irq_q;

   AST_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
      (&mask_i) |=> !irq_q); // R8

   AST_NONE_PENDING: assert property (@(posedge clk) disable iff (rst)
      (pend_i == '0) |=> !irq_q); // R8

endmodule

// File: rtl/ideirq_agg.sv
module ideirq_agg
   import ideirq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PRI_ADDR  = 8'h20,
   parameter logic [ADDR_W-1:0] TIM_ADDR  = 8'h24,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h2A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        drv_irq,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] cfg_raddr,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              irq_req
);

   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("ideirq_agg: DATA_W must equal the byte width");
   end
   if (PRI_ADDR == TIM_ADDR || PRI_ADDR == MODE_ADDR || TIM_ADDR == MODE_ADDR) begin : g_bad_addr
      $error("ideirq_agg: register addresses must differ");
   end

   logic [NCH-1:0] pend;
   logic [NCH-1:0] clr;
   logic [NCH-1:0] mask;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ideirq_chan u_chan (
         .clk    (clk),
         .rst    (rst),
         .drv_i  (drv_irq[c]),
         .clr_i  (clr[c]),
         .pend_o (pend[c])
      );
   end

   ideirq_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PRI_ADDR  (PRI_ADDR),
      .TIM_ADDR  (TIM_ADDR),
      .MODE_ADDR (MODE_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cfg_wr_en),
      .waddr  (cfg_addr),
      .wdata  (cfg_wdata),
      .raddr  (cfg_raddr),
      .pend_i (pend),
      .clr_o  (clr),
      .mask_o (mask),
      .rdata  (cfg_rdata)
   );

   ideirq_reduce u_reduce (
      .clk    (clk),
      .rst    (rst),
      .pend_i (pend),
      .mask_i (mask),
      .irq_o  (irq_req)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> !irq_req); // R10

endmodule

// File: tb/ideirq_agg_test.sv
module ideirq_agg_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] A_PRI  = 6'h05;
   localparam logic [5:0] A_TIM  = 6'h0C;
   localparam logic [5:0] A_MODE = 6'h13;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] drv_irq = 2'b00;
   logic       cfg_wr_en = 1'b0;
   logic [5:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [5:0] cfg_raddr = '0;
   logic [7:0] cfg_rdata;
   logic       irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ideirq_agg #(
      .ADDR_W(6), .DATA_W(8),
      .PRI_ADDR(A_PRI), .TIM_ADDR(A_TIM), .MODE_ADDR(A_MODE)
   ) uut (
      .clk(clk), .rst(rst), .drv_irq(drv_irq),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .irq_req(irq_req)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
      cfg_raddr = a;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic drive(input logic [1:0] v);
      @(negedge clk);
      drv_irq = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      rd_check("R10 reset primary", A_PRI, 8'h00);
      rd_check("R10 reset timing", A_TIM, 8'h00);
      rd_check("R10 reset mode", A_MODE, 8'h00);
      check("R10 reset irq", {7'd0, irq_req}, 8'h00);
   endtask

   task automatic t_edges;
      drive(2'b01);
      rd_check("R3 rise ch0 mode", A_MODE, 8'h04);
      rd_check("R2 mirror ch0 primary", A_PRI, 8'h04);
      rd_check("R2 timing untouched", A_TIM, 8'h00);
      check("R8 irq lags one cycle", {7'd0, irq_req}, 8'h00);
      @(negedge clk);
      check("R8 irq raised", {7'd0, irq_req}, 8'h01);
      drive(2'b00);
      rd_check("R4 fall ch0 mode", A_MODE, 8'h00);
      rd_check("R2 mirror ch0 cleared", A_PRI, 8'h00);
      @(negedge clk);
      check("R8 irq dropped", {7'd0, irq_req}, 8'h00);
   endtask

   task automatic t_ack;
      drive(2'b10);
      rd_check("R3 rise ch1 mode", A_MODE, 8'h08);
      rd_check("R2 mirror ch1 timing", A_TIM, 8'h10);
      wr(A_TIM, 8'h00);
      rd_check("R5 zero write keeps ch1", A_MODE, 8'h08);
      wr(A_TIM, 8'h10);
      rd_check("R5 ack ch1 via timing", A_MODE, 8'h00);
      drive(2'b11);
      rd_check("R5 ch0 pending", A_MODE, 8'h04);
      wr(A_PRI, 8'h04);
      rd_check("R5 ack ch0 via primary", A_MODE, 8'h00);
      drive(2'b00);
      drive(2'b11);
      rd_check("R5 both pending", A_MODE, 8'h0C);
      wr(A_MODE, 8'h04);
      rd_check("R5 ack ch0 via mode", A_MODE, 8'h08);
      rd_check("R2 primary follows mode ack", A_PRI, 8'h00);
      wr(A_MODE, 8'h08);
      rd_check("R5 ack ch1 via mode", A_MODE, 8'h00);
      rd_check("R2 timing follows mode ack", A_TIM, 8'h00);
      wr(A_MODE, 8'h0C);
      rd_check("R5 write cannot set", A_MODE, 8'h00);
      drive(2'b00);
   endtask

   task automatic t_collide;
      @(negedge clk);
      drv_irq = 2'b01;
      cfg_wr_en = 1'b1; cfg_addr = A_MODE; cfg_wdata = 8'h04;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      rd_check("R6 rise beats ack", A_MODE, 8'h04);
      drive(2'b00);
      rd_check("R6 cleanup", A_MODE, 8'h00);
   endtask

   task automatic t_mask;
      wr(A_MODE, 8'h10);
      rd_check("R7 mask0 readback", A_MODE, 8'h10);
      drive(2'b01);
      @(negedge clk);
      check("R8 masked ch0 no irq", {7'd0, irq_req}, 8'h00);
      wr(A_MODE, 8'h00);
      check("R8 unmask lag", {7'd0, irq_req}, 8'h00);
      @(negedge clk);
      check("R8 unmask raises", {7'd0, irq_req}, 8'h01);
      drive(2'b11);
      wr(A_MODE, 8'h30);
      @(negedge clk);
      check("R8 both masked", {7'd0, irq_req}, 8'h00);
      wr(A_MODE, 8'h20);
      @(negedge clk);
      check("R8 ch1 masked ch0 live", {7'd0, irq_req}, 8'h01);
      rd_check("R7 mode with mask1", A_MODE, 8'h2C);
      wr(A_MODE, 8'h2C);
      rd_check("R5 ack both keep mask", A_MODE, 8'h20);
      @(negedge clk);
      check("R8 acked no irq", {7'd0, irq_req}, 8'h00);
      drive(2'b00);
      wr(A_MODE, 8'h00);
   endtask

   task automatic t_plain;
      wr(A_PRI, 8'hFF);
      rd_check("R9 primary storage", A_PRI, 8'hFB);
      wr(A_TIM, 8'hA5);
      rd_check("R9 timing storage", A_TIM, 8'hA5);
      wr(A_MODE, 8'hFF);
      rd_check("R1 mode spare bits zero", A_MODE, 8'h30);
      wr(A_MODE, 8'h00);
      drive(2'b10);
      rd_check("R2 timing mirror with storage", A_TIM, 8'hB5);
      wr(A_TIM, 8'hEF);
      rd_check("R9 timing rewrite keeps pending", A_TIM, 8'hFF);
      drive(2'b00);
      rd_check("R4 timing after fall", A_TIM, 8'hEF);
   endtask

   task automatic t_unmapped;
      wr(6'h00, 8'hFF);
      wr(6'h3F, 8'hFF);
      rd_check("R10 unmapped reads zero", 6'h00, 8'h00);
      rd_check("R10 unmapped high reads zero", 6'h3F, 8'h00);
      rd_check("R10 primary unchanged", A_PRI, 8'hFB);
      rd_check("R10 mode unchanged", A_MODE, 8'h00);
   endtask

   task automatic t_rereset;
      drive(2'b01);
      wr(A_MODE, 8'h20);
      @(negedge clk);
      rst = 1'b1;
      drv_irq = 2'b00;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      t_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_edges();
      t_ack();
      t_collide();
      t_mask();
      t_plain();
      t_unmapped();
      t_rereset();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule